// File: doc/BRIEF.md
# Home Directory Coherence Controller

This controller is the home node of a distributed shared memory built from clusters. It keeps one directory entry for every memory block homed at this node. An entry holds a block state and a presence bitmap with one bit per cluster. The block state is UNCACHED, SHARED or EXCLUSIVE. Other clusters send read-miss and write-miss requests. For each request the controller looks up the entry and takes one of three actions: it replies with data, it forwards the request to the cluster that owns the block exclusively, or it sends invalidations to every cluster that shares the block. It then writes back the new entry.

The controller handles one transaction at a time and runs as a state machine with five states. IDLE accepts a request and starts the directory read, which is the accept transition. LOOKUP gets the entry, picks the action and writes the new entry. From there the decide transition leads either to SEND, which holds one message until it is taken, or to INVAL, which emits one invalidation per cycle. WAIT counts acknowledgments. The complete transition leaves WAIT for SEND when an exclusive grant is still owed, and for IDLE otherwise. While in WAIT, a new request to the busy block gets a negative acknowledgment so the requester retries. Requests to other blocks are held off.

All outgoing traffic uses one valid/ready message channel that carries a kind, a destination, the original requester and the block index. Acknowledgments come back as single-cycle pulses. These are either invalidation acks or the completion notice of a forwarded request.

Top module: `home_dir_ctrl`

## Requirements
- R1: After reset every entry reads as UNCACHED with an empty bitmap, no message is pending and req_ready is high. The first read miss to any block is answered with a read-data message (kind 0) to the requester.
- R2: A read miss to an UNCACHED or SHARED block sends kind 0 with msg_dest and msg_req both equal to the requester. The entry becomes SHARED and the requester's bit is added.
- R3: A read miss to an EXCLUSIVE block sends a read forward (kind 2) to the owner, with msg_req set to the requester. The entry becomes SHARED with the owner and requester bits set. The transaction closes on one ack.
- R4: A write miss to an UNCACHED block sends an exclusive grant (kind 1) to the requester. The entry becomes EXCLUSIVE with only the requester's bit set.
- R5: A write miss to a SHARED block sends an invalidation (kind 4) to every set cluster other than the requester. The invalidations go out in ascending cluster index, one per cycle while msg_ready is high, and each carries the requester in msg_req.
- R6: After invalidations, the grant (kind 1) to the writer is sent only once one ack per invalidation has arrived. If the writer was the only sharer, the grant is sent at once.
- R7: A write miss to a block held EXCLUSIVE by another cluster sends a write forward (kind 3) to the owner. Afterwards the writer is the sole owner, so the next read miss is forwarded to it.
- R8: While acks are outstanding, a request to the same block is answered with a negative acknowledgment (kind 5) to its source and leaves the entry unchanged. A request to any other block sees req_ready low.
- R9: A message held with msg_ready low keeps msg_valid and all its fields stable until it is taken.
- R10: A write miss from the cluster that already owns the block exclusively is granted at once with kind 1 and is not forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_write | input | 1 | 1 = write miss, 0 = read miss |
| req_src | input | CW | Requesting cluster |
| req_block | input | BW | Block index in home memory |
| ack_valid | input | 1 | One invalidation ack or forward completion |
| msg_valid | output | 1 | Outgoing message present |
| msg_ready | input | 1 | Outgoing message taken |
| msg_kind | output | 3 | 0 read data, 1 exclusive grant, 2 read forward, 3 write forward, 4 invalidate, 5 negative ack |
| msg_dest | output | CW | Destination cluster |
| msg_req | output | CW | Original requester |
| msg_block | output | BW | Block index |

## Verification
The protocol paths are driven by a table of request streams. These include first touches of fresh blocks, reads that follow a write, and writes that follow a forward. Each expected message tells whether the directory recorded the right state and owner: a wrong owner shows up as a forward to the wrong cluster, and a lost SHARED state shows up as a grant where invalidations were due. Directed sequences build sharer sets in scrambled order to check that invalidations come out ascending and skip the writer. Acks are withheld one at a time to show that the grant waits, and a retry to the busy block is sent mid-transaction to show the negative acknowledgment leaves the directory unchanged. A stalled output channel checks that the held message stays put.

// File: rtl/dir_pkg.sv
package dir_pkg;
    typedef enum logic [1:0] {
        BS_UNC = 2'd0,
        BS_SHR = 2'd1,
        BS_EXC = 2'd2
    } blk_state_e;

    typedef enum logic [2:0] {
        MK_RD_DATA = 3'd0,
        MK_WR_DATA = 3'd1,
        MK_FWD_RD  = 3'd2,
        MK_FWD_WR  = 3'd3,
        MK_INV     = 3'd4,
        MK_NACK    = 3'd5
    } msg_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_SEND,
        ST_INVAL,
        ST_WAIT
    } ctl_state_e;
endpackage

// File: rtl/dir_entry_ram.sv
module dir_entry_ram #(
    parameter int DEPTH = 64,
    parameter int WIDTH = 18,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic [AW-1:0]    rd_addr,
    output logic [WIDTH-1:0] rd_data,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [DEPTH-1:0] written;

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    // Entries never written read as all zero: UNCACHED, empty bitmap.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     written <= '0;
        else if (wr_en) written[wr_addr] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rd_en) rd_data <= written[rd_addr] ? mem[rd_addr] : '0;
    end
endmodule

// File: rtl/dir_low_pick.sv
module dir_low_pick #(
    parameter int N = 16,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  vec,
    output logic [IW-1:0] idx,
    output logic          any
);
    always_comb begin
        idx = '0;
        any = |vec;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/home_dir_ctrl.sv
module home_dir_ctrl #(
    parameter int NCLU  = 16,
    parameter int DEPTH = 64,
    localparam int CW = $clog2(NCLU),
    localparam int BW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [CW-1:0] req_src,
    input  logic [BW-1:0] req_block,
    input  logic          ack_valid,
    output logic          msg_valid,
    input  logic          msg_ready,
    output logic [2:0]    msg_kind,
    output logic [CW-1:0] msg_dest,
    output logic [CW-1:0] msg_req,
    output logic [BW-1:0] msg_block
);
    import dir_pkg::*;

    localparam int EW = NCLU + 2;
    localparam int KW = $clog2(NCLU + 1);

    ctl_state_e state_q, state_d;
    logic            cur_wr;
    logic [CW-1:0]   cur_src;
    logic [BW-1:0]   cur_blk;
    logic [KW-1:0]   acks_left;
    logic            grant_pend;
    logic [NCLU-1:0] inv_mask;
    msg_kind_e       kind_q;

    logic [EW-1:0]   ent_rd, ent_wr;
    blk_state_e      ent_st;
    logic [NCLU-1:0] ent_pv, src_bit, sharers;
    logic [CW-1:0]   owner_idx, inv_idx;
    logic            owner_any, inv_any;
    msg_kind_e       act_kind;
    logic            act_inv, req_fire;

    function automatic logic [KW-1:0] count_ones(input logic [NCLU-1:0] v);
        logic [KW-1:0] n;
        n = '0;
        for (int i = 0; i < NCLU; i++) n = n + KW'(v[i]);
        return n;
    endfunction

    dir_entry_ram #(.DEPTH(DEPTH), .WIDTH(EW)) u_ram (
        .clk(clk), .rst_n(rst_n),
        .rd_en(req_fire && state_q == ST_IDLE), .rd_addr(req_block), .rd_data(ent_rd),
        .wr_en(state_q == ST_LOOKUP), .wr_addr(cur_blk), .wr_data(ent_wr)
    );

    dir_low_pick #(.N(NCLU)) u_owner (.vec(ent_pv),   .idx(owner_idx), .any(owner_any));
    dir_low_pick #(.N(NCLU)) u_inv   (.vec(inv_mask), .idx(inv_idx),   .any(inv_any));

    assign ent_st  = blk_state_e'(ent_rd[EW-1 -: 2]);
    assign ent_pv  = ent_rd[NCLU-1:0];
    assign src_bit = NCLU'(1) << cur_src;
    assign sharers = ent_pv & ~src_bit;
    assign ent_wr  = cur_wr ? {BS_EXC, src_bit} : {BS_SHR, ent_pv | src_bit};

    assign req_ready = (state_q == ST_IDLE) ||
                       (state_q == ST_WAIT && acks_left != '0 && !msg_valid && req_block == cur_blk);
    assign req_fire  = req_valid && req_ready;

    // Action chosen from the looked-up entry.
    always_comb begin
        act_kind = MK_RD_DATA;
        act_inv  = 1'b0;
        if (!cur_wr) begin
            if (ent_st == BS_EXC && owner_any && owner_idx != cur_src) act_kind = MK_FWD_RD;
        end else begin
            act_kind = MK_WR_DATA;
            if (ent_st == BS_SHR && sharers != '0) act_inv = 1'b1;
            else if (ent_st == BS_EXC && owner_any && owner_idx != cur_src) act_kind = MK_FWD_WR;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_fire) state_d = ST_LOOKUP;
            ST_LOOKUP: state_d = act_inv ? ST_INVAL : ST_SEND;
            ST_SEND:   if (msg_ready) state_d = (acks_left != '0) ? ST_WAIT : ST_IDLE;
            ST_INVAL:  if (!inv_any && (!msg_valid || msg_ready)) state_d = ST_WAIT;
            ST_WAIT:   if (acks_left == '0 && !msg_valid) state_d = grant_pend ? ST_SEND : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_wr <= 1'b0; cur_src <= '0; cur_blk <= '0;
            acks_left <= '0; grant_pend <= 1'b0; inv_mask <= '0;
            msg_valid <= 1'b0; kind_q <= MK_RD_DATA;
            msg_dest <= '0; msg_req <= '0; msg_block <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (req_fire) begin
                    cur_wr <= req_write; cur_src <= req_src; cur_blk <= req_block;
                end
                ST_LOOKUP: begin
                    grant_pend <= act_inv;
                    inv_mask   <= act_inv ? sharers : '0;
                    acks_left  <= act_inv ? count_ones(sharers) :
                                  (act_kind == MK_FWD_RD || act_kind == MK_FWD_WR) ? KW'(1) : '0;
                    msg_valid  <= !act_inv;
                    kind_q     <= act_kind;
                    msg_dest   <= (act_kind == MK_FWD_RD || act_kind == MK_FWD_WR) ? owner_idx : cur_src;
                    msg_req    <= cur_src;
                    msg_block  <= cur_blk;
                end
                ST_SEND: if (msg_ready) msg_valid <= 1'b0;
                ST_INVAL: if (!msg_valid || msg_ready) begin
                    if (inv_any) begin
                        msg_valid <= 1'b1; kind_q <= MK_INV; msg_dest <= inv_idx;
                        inv_mask[inv_idx] <= 1'b0;
                    end else begin
                        msg_valid <= 1'b0;
                    end
                end
                ST_WAIT: begin
                    if (msg_valid && msg_ready) begin
                        msg_valid <= 1'b0;
                    end else if (req_fire) begin
                        msg_valid <= 1'b1; kind_q <= MK_NACK;
                        msg_dest <= req_src; msg_req <= req_src; msg_block <= req_block;
                    end else if (acks_left == '0 && !msg_valid && grant_pend) begin
                        msg_valid <= 1'b1; kind_q <= MK_WR_DATA; grant_pend <= 1'b0;
                        msg_dest <= cur_src; msg_req <= cur_src; msg_block <= cur_blk;
                    end
                end
                default: ;
            endcase
            if (state_q != ST_IDLE && state_q != ST_LOOKUP && ack_valid && acks_left != '0)
                acks_left <= acks_left - KW'(1);
        end
    end

    assign msg_kind = kind_q;

    // R2: read data always goes back to the cluster that asked.
    p_rd_home_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_kind == MK_RD_DATA) |-> (msg_dest == msg_req));
    // R3 / R7: a forward never targets its own requester.
    p_fwd_other_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && (msg_kind == MK_FWD_RD || msg_kind == MK_FWD_WR)) |-> (msg_dest != msg_req));
    // R5: back-to-back invalidations climb in cluster index.
    p_inv_ascend_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_ready && msg_kind == MK_INV) |=>
        (!(msg_valid && msg_kind == MK_INV) || msg_dest > $past(msg_dest)));
    // R6: no grant while acknowledgments remain.
    p_grant_acked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_kind == MK_WR_DATA) |-> (acks_left == '0));
    // R8: a request accepted mid-transaction yields a negative ack.
    p_busy_nack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && state_q == ST_WAIT) |=> (msg_valid && msg_kind == MK_NACK));
    // R9: a stalled message holds.
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_kind) && $stable(msg_dest)
                                       && $stable(msg_req) && $stable(msg_block)));
endmodule

// File: tb/home_dir_ctrl_test.sv
module home_dir_ctrl_test;
    localparam int K_RD = 0, K_WR = 1, K_FRD = 2, K_FWR = 3, K_INV = 4, K_NACK = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0, req_write = 1'b0, ack_valid = 1'b0, msg_ready = 1'b1;
    logic [3:0] req_src = '0;
    logic [5:0] req_block = '0;
    logic       req_ready, msg_valid;
    logic [2:0] msg_kind;
    logic [3:0] msg_dest, msg_req;
    logic [5:0] msg_block;

    int nchk = 0, nerr = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    home_dir_ctrl #(.NCLU(16), .DEPTH(64)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_src(req_src), .req_block(req_block), .ack_valid(ack_valid),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_kind(msg_kind),
        .msg_dest(msg_dest), .msg_req(msg_req), .msg_block(msg_block)
    );

    // {write, src[4], block[8], kind[3], dest[4], req[4]}
    localparam logic [23:0] VEC [12] = '{
        {1'b0, 4'd3,  8'd5,  3'd0, 4'd3,  4'd3 },  // R1 fresh block
        {1'b0, 4'd5,  8'd5,  3'd0, 4'd5,  4'd5 },  // R2 shared read
        {1'b1, 4'd9,  8'd10, 3'd1, 4'd9,  4'd9 },  // R4 uncached write
        {1'b0, 4'd2,  8'd10, 3'd2, 4'd9,  4'd2 },  // R3 read of exclusive
        {1'b0, 4'd4,  8'd10, 3'd0, 4'd4,  4'd4 },  // R3 now shared
        {1'b1, 4'd9,  8'd11, 3'd1, 4'd9,  4'd9 },  // R4
        {1'b1, 4'd1,  8'd11, 3'd3, 4'd9,  4'd1 },  // R7 write forward
        {1'b0, 4'd6,  8'd11, 3'd2, 4'd1,  4'd6 },  // R7 new owner
        {1'b1, 4'd12, 8'd20, 3'd1, 4'd12, 4'd12},  // R4
        {1'b1, 4'd12, 8'd20, 3'd1, 4'd12, 4'd12},  // R10 owner rewrite
        {1'b0, 4'd0,  8'd30, 3'd0, 4'd0,  4'd0 },  // R1
        {1'b1, 4'd0,  8'd30, 3'd1, 4'd0,  4'd0 }   // R6 sole sharer
    };

    function automatic string vec_tag(input int i);
        case (i)
            0, 10:   return "R1";
            1:       return "R2";
            2, 5, 8: return "R4";
            3, 4:    return "R3";
            6, 7:    return "R7";
            9:       return "R10";
            default: return "R6";
        endcase
    endfunction

    function automatic int pk(input int k, input int d, input int q);
        return k * 256 + d * 16 + q;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic send_req(input bit w, input int src, input int blk);
        @(negedge clk);
        req_write = w; req_src = 4'(src); req_block = 6'(blk); req_valid = 1'b1;
        for (int n = 0; n < 20; n++) begin
            #1;
            if (req_ready) break;
            @(negedge clk);
        end
        @(posedge clk);
        #1 req_valid = 1'b0;
    endtask

    task automatic get_msg(output int k, output int d, output int q, output int b, output bit seen);
        seen = 1'b0; k = -1; d = 0; q = 0; b = 0;
        for (int n = 0; n < 20 && !seen; n++) begin
            @(negedge clk);
            if (msg_valid) begin
                seen = 1'b1; k = msg_kind; d = msg_dest; q = msg_req; b = msg_block;
            end
        end
        if (seen && msg_ready) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic pulse_ack();
        @(negedge clk) ack_valid = 1'b1;
        @(negedge clk) ack_valid = 1'b0;
    endtask

    task automatic xact(input bit w, input int src, input int blk,
                        input int ek, input int ed, input int eq, input string tag);
        int k, d, q, b;
        bit seen;
        send_req(w, src, blk);
        get_msg(k, d, q, b, seen);
        chk(seen && pk(k, d, q) == pk(ek, ed, eq) && b == blk, tag, "kind/dest/req",
            pk(k, d, q), pk(ek, ed, eq));
        if (ek == K_FRD || ek == K_FWR) pulse_ack();
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog: actual running expected done");
        finish_run();
    end

    initial begin
        int k, d, q, b;
        bit seen;
        int readers [4];
        int invs [3];
        readers = '{14, 0, 8, 6};
        invs = '{0, 6, 14};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(msg_valid == 1'b0, "R1", "msg_valid after reset", msg_valid, 0);
        chk(req_ready == 1'b1, "R1", "req_ready after reset", req_ready, 1);

        for (int i = 0; i < 12; i++) begin
            xact(VEC[i][23], int'(VEC[i][22:19]), int'(VEC[i][18:11]),
                 int'(VEC[i][10:8]), int'(VEC[i][7:4]), int'(VEC[i][3:0]), vec_tag(i));
        end

        // R5/R6/R8: block 5 shared by {3,5,15}; cluster 5 writes.
        xact(1'b0, 15, 5, K_RD, 15, 15, "R2");
        send_req(1'b1, 5, 5);
        get_msg(k, d, q, b, seen);
        chk(seen && pk(k, d, q) == pk(K_INV, 3, 5), "R5", "first invalidation", pk(k, d, q), pk(K_INV, 3, 5));
        @(negedge clk);
        chk(msg_valid && pk(msg_kind, msg_dest, msg_req) == pk(K_INV, 15, 5), "R5", "next-cycle invalidation",
            pk(msg_kind, msg_dest, msg_req), pk(K_INV, 15, 5));
        repeat (3) @(negedge clk);
        chk(msg_valid == 1'b0, "R6", "no grant before acks", msg_valid, 0);
        pulse_ack();
        repeat (3) @(negedge clk);
        chk(msg_valid == 1'b0, "R6", "no grant after one of two acks", msg_valid, 0);
        xact(1'b1, 7, 5, K_NACK, 7, 7, "R8");
        @(negedge clk);
        req_write = 1'b0; req_src = 4'd2; req_block = 6'd6; req_valid = 1'b1;
        #1;
        chk(req_ready == 1'b0, "R8", "other block held off", req_ready, 0);
        @(negedge clk) req_valid = 1'b0;
        pulse_ack();
        get_msg(k, d, q, b, seen);
        chk(seen && pk(k, d, q) == pk(K_WR, 5, 5), "R6", "grant after all acks", pk(k, d, q), pk(K_WR, 5, 5));
        xact(1'b0, 3, 5, K_FRD, 5, 3, "R8");  // owner is 5, not the refused 7

        // R5: four sharers added out of order, writer among them.
        for (int i = 0; i < 4; i++) xact(1'b0, readers[i], 40, K_RD, readers[i], readers[i], "R2");
        send_req(1'b1, 8, 40);
        for (int i = 0; i < 3; i++) begin
            get_msg(k, d, q, b, seen);
            chk(seen && pk(k, d, q) == pk(K_INV, invs[i], 8), "R5", "ascending invalidation",
                pk(k, d, q), pk(K_INV, invs[i], 8));
        end
        repeat (3) pulse_ack();
        get_msg(k, d, q, b, seen);
        chk(seen && pk(k, d, q) == pk(K_WR, 8, 8), "R6", "grant after three acks", pk(k, d, q), pk(K_WR, 8, 8));

        // R9: stalled output channel.
        msg_ready = 1'b0;
        send_req(1'b0, 2, 50);
        get_msg(k, d, q, b, seen);
        repeat (3) @(negedge clk);
        chk(msg_valid && pk(msg_kind, msg_dest, msg_req) == pk(K_RD, 2, 2) && msg_block == 6'd50,
            "R9", "held message", pk(msg_kind, msg_dest, msg_req), pk(K_RD, 2, 2));
        msg_ready = 1'b1;
        @(negedge clk);
        chk(msg_valid == 1'b0, "R9", "message taken after release", msg_valid, 0);

        finish_run();
    end
endmodule